// File: doc/BRIEF.md
# Serial Audio Event Flag and Interrupt Controller

This block collects the condition signals of a serial audio port and turns them into one interrupt line. Nine of the conditions arrive as single-cycle event pulses and are caught in sticky flags. Examples are a transmit underrun, a receive overrun, a frame-sync error and end of transfer. The other four are level conditions, such as data ready or space available, and they appear in the status word exactly as they are driven.

A small write port carries two kinds of word, selected by one select bit. An enable word decides which status bits may raise the interrupt. A clear word removes sticky flags wherever it carries a one. The status word is always visible on a read port.

The interrupt is a register. It goes high one cycle after the AND of status and enable becomes nonzero.

Status layout, which software decodes:

| Bits | Kind | Source |
|------|------|--------|
| 0, 1, 2 | live level | `lvlIn[0]`, `lvlIn[1]`, `lvlIn[2]` |
| 3 to 11 | sticky flag | `evtPulse[0]` to `evtPulse[8]` |
| 12 | live level | `lvlIn[3]` |

Examples of sticky positions: bit 3 is end of transfer, bit 5 is underrun, bit 6 is overrun, bit 8 is frame error and bit 11 is suspended.

Top module: `event_flag_ctrl`

## Requirements
- R1: After reset, including a reset asserted in the middle of operation, every sticky flag is 0, the enable word is 0 and `irqOut` is 0.
- R2: A one-cycle pulse on `evtPulse[i]` sets status bit 3+i at the next clock edge. The bit stays set after the pulse ends until it is cleared.
- R3: A clear write (`wrEn`=1, `wrSel`=1) clears each sticky bit 3..11 whose bit in `wrData` is 1, at the next edge. Sticky bits written with 0 keep their value.
- R4: Ones in bits 0..2 of a clear word have no effect. The status keeps its live levels and its sticky flags.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the event wins and the flag is set afterwards.
- R6: Status bits 0, 1, 2 and 12 equal `lvlIn[0]`, `lvlIn[1]`, `lvlIn[2]` and `lvlIn[3]` in the same cycle. They hold no memory.
- R7: An enable write (`wrEn`=1, `wrSel`=0) loads the enable word from `wrData[10:0]`, where enable bit k gates status bit k. After every edge, `irqOut` equals the OR of (status AND enable) as it stood before that edge.
- R8: Status bits 11 and 12 have no enable bit and never raise `irqOut`.
- R9: A clear word of all ones clears all nine sticky flags in one write.
- R10: A clear write leaves the enable word unchanged. An enable write leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lvlIn | input | 4 | Live level conditions for status bits 0, 1, 2, 12 |
| evtPulse | input | 9 | Event pulses for sticky status bits 3..11 |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 1 | Write target: 0 = enable word, 1 = clear word |
| wrData | input | 12 | Write data |
| statusOut | output | 13 | Status read port |
| irqOut | output | 1 | Registered interrupt |

## Verification
Two things can meet in one cycle: a clear write and a new event on the same sticky bit. The test provokes this by driving an end-of-transfer pulse in the same cycle as an all-ones clear word. It then reads the status after the edge and expects bit 3 still set, while the suspended flag, cleared by the same write, reads 0.

A second collision drives an enable write in the same cycle as a live level change. The interrupt is judged one cycle later against the registered AND.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int STAT_W    = 13;
  localparam int EN_W      = 11;
  localparam int STICKY_LO = 3;
  localparam int STICKY_HI = 11;
  localparam int STICKY_N  = STICKY_HI - STICKY_LO + 1;
  localparam int LIVE_N    = STAT_W - STICKY_N;
  localparam int WDATA_W   = STICKY_HI + 1;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_CLEAR  = 1'b1
  } wrTarget_e;

  typedef struct packed {
    logic                enLoad;
    logic [EN_W-1:0]     enWord;
    logic [STICKY_N-1:0] clrMask;
  } evfStrobe_t;

  function automatic int liveBitPos(input int idx);
    return (idx < STICKY_LO) ? idx : STICKY_HI + 1 + (idx - STICKY_LO);
  endfunction
endpackage

// File: rtl/evf_ctrl.sv
module evf_ctrl
  import evf_pkg::*;
(
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [WDATA_W-1:0] wrData,
  output evfStrobe_t         strb
);
  wrTarget_e target;

  always_comb begin
    target       = wrTarget_e'(wrSel);
    strb.enLoad  = wrEn && (target == SEL_ENABLE);
    strb.enWord  = wrData[EN_W-1:0];
    strb.clrMask = (wrEn && (target == SEL_CLEAR)) ? wrData[STICKY_HI:STICKY_LO]
                                                   : '0;
  end
endmodule

// File: rtl/evf_datapath.sv
module evf_datapath
  import evf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  evfStrobe_t          strb,
  input  logic [STICKY_N-1:0] evtPulse,
  input  logic [LIVE_N-1:0]   lvlIn,
  output logic [STAT_W-1:0]   statusOut,
  output logic [EN_W-1:0]     enableOut,
  output logic                irqOut
);
  logic [STICKY_N-1:0] flagVec;
  logic [EN_W-1:0]     enableQ;
  logic                irqQ;

  for (genvar i = 0; i < STICKY_N; i++) begin : g_flag
    logic bitQ;
    always_ff @(posedge clk) begin
      if (!rstN) bitQ <= 1'b0;
      else       bitQ <= (bitQ & ~strb.clrMask[i]) | evtPulse[i];
    end
    assign flagVec[i] = bitQ;
  end

  always_comb begin
    statusOut = '0;
    for (int i = 0; i < LIVE_N; i++)
      statusOut[liveBitPos(i)] = lvlIn[i];
    for (int i = 0; i < STICKY_N; i++)
      statusOut[STICKY_LO + i] = flagVec[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strb.enLoad) enableQ <= strb.enWord;
      irqQ <= |(statusOut[EN_W-1:0] & enableQ);
    end
  end

  assign enableOut = enableQ;
  assign irqOut    = irqQ;
endmodule

// File: rtl/event_flag_ctrl.sv
module event_flag_ctrl
  import evf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [LIVE_N-1:0]   lvlIn,
  input  logic [STICKY_N-1:0] evtPulse,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [WDATA_W-1:0]  wrData,
  output logic [STAT_W-1:0]   statusOut,
  output logic                irqOut
);
  evfStrobe_t      strb;
  logic [EN_W-1:0] enableQ;

  evf_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strb   (strb)
  );

  evf_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evtPulse  (evtPulse),
    .lvlIn     (lvlIn),
    .statusOut (statusOut),
    .enableOut (enableQ),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/evf_chk.sv
module evf_chk
  import evf_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [LIVE_N-1:0]   lvlIn,
  input logic [STICKY_N-1:0] evtPulse,
  input logic                wrEn,
  input logic                wrSel,
  input logic [WDATA_W-1:0]  wrData,
  input logic [STAT_W-1:0]   statusOut,
  input logic [EN_W-1:0]     enWord,
  input logic                irqOut
);
  logic [STICKY_N-1:0] clrVec;
  assign clrVec = (wrEn && wrSel) ? wrData[STICKY_HI:STICKY_LO] : '0;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(evtPulse) & ~statusOut[STICKY_HI:STICKY_LO]) == '0));

  assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusOut[STICKY_HI:STICKY_LO]) & ~$past(clrVec))
               & ~statusOut[STICKY_HI:STICKY_LO]) == '0));

  assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(clrVec) & ~$past(evtPulse))
               & statusOut[STICKY_HI:STICKY_LO]) == '0));

  assert_live_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[STICKY_LO-1:0] == lvlIn[STICKY_LO-1:0])
    && (statusOut[STAT_W-1] == lvlIn[LIVE_N-1]));

  assert_irq_timing_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusOut[EN_W-1:0] & enWord))));

  assert_enable_kept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> $stable(enWord));
endmodule

bind event_flag_ctrl evf_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lvlIn     (lvlIn),
  .evtPulse  (evtPulse),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrData    (wrData),
  .statusOut (statusOut),
  .enWord    (enableQ),
  .irqOut    (irqOut)
);

// File: tb/tb_event_flag_ctrl.sv
module tb_event_flag_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  lvlIn;
  logic [8:0]  evtPulse;
  logic        wrEn;
  logic        wrSel;
  logic [11:0] wrData;
  logic [12:0] statusOut;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  event_flag_ctrl dut (
    .clk(clk), .rstN(rstN), .lvlIn(lvlIn), .evtPulse(evtPulse),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  // Vector fields: lvl[4], evt[9], wrEn, wrSel, data[12], expStat[13], expIrq, req[4]
  localparam int NV = 19;
  localparam logic [44:0] VEC [NV] = '{
    {4'h0, 9'h000, 1'b1, 1'b0, 12'h7FF, 13'h0000, 1'b0, 4'd10},
    {4'h1, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0001, 1'b1, 4'd6},
    {4'h0, 9'h004, 1'b0, 1'b0, 12'h000, 13'h0020, 1'b0, 4'd2},
    {4'h0, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0020, 1'b1, 4'd2},
    {4'h0, 9'h000, 1'b1, 1'b1, 12'h020, 13'h0000, 1'b1, 4'd3},
    {4'h0, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0000, 1'b0, 4'd7},
    {4'h0, 9'h102, 1'b0, 1'b0, 12'h000, 13'h0810, 1'b0, 4'd2},
    {4'h0, 9'h000, 1'b1, 1'b1, 12'h010, 13'h0800, 1'b1, 4'd3},
    {4'h0, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0800, 1'b0, 4'd8},
    {4'h8, 9'h000, 1'b0, 1'b0, 12'h000, 13'h1800, 1'b0, 4'd8},
    {4'h8, 9'h000, 1'b1, 1'b1, 12'h007, 13'h1800, 1'b0, 4'd4},
    {4'h8, 9'h001, 1'b1, 1'b1, 12'hFFF, 13'h1008, 1'b0, 4'd5},
    {4'h0, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0008, 1'b1, 4'd10},
    {4'h0, 9'h000, 1'b1, 1'b0, 12'h000, 13'h0008, 1'b1, 4'd7},
    {4'h0, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0008, 1'b0, 4'd7},
    {4'h0, 9'h000, 1'b1, 1'b1, 12'hFFF, 13'h0000, 1'b0, 4'd9},
    {4'h4, 9'h000, 1'b1, 1'b0, 12'h004, 13'h0004, 1'b0, 4'd7},
    {4'h4, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0004, 1'b1, 4'd7},
    {4'h0, 9'h000, 1'b0, 1'b0, 12'h000, 13'h0000, 1'b0, 4'd6}
  };

  function automatic string reqName(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";
      4: return "R4";   5: return "R5";   6: return "R6";
      7: return "R7";   8: return "R8";   9: return "R9";
      10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic checkStat(input string req, input logic [12:0] exp);
    nChecks++;
    if (statusOut !== exp) begin
      nFails++;
      $display("FAIL %s status got %h expected %h", req, statusOut, exp);
    end
  endtask

  task automatic checkIrq(input string req, input logic exp);
    nChecks++;
    if (irqOut !== exp) begin
      nFails++;
      $display("FAIL %s irq got %b expected %b", req, irqOut, exp);
    end
  endtask

  task automatic idle();
    evtPulse = '0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  initial begin
    rstN = 1'b0; lvlIn = '0; idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkStat("R1", 13'h0000);
    checkIrq("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      {lvlIn, evtPulse, wrEn, wrSel, wrData} = VEC[i][44:18];
      @(negedge clk);
      checkStat(reqName(int'(VEC[i][3:0])), VEC[i][17:5]);
      checkIrq(reqName(int'(VEC[i][3:0])), VEC[i][4]);
    end

    // R9: all sticky flags at once, then one all-ones clear
    idle(); evtPulse = 9'h1FF;
    @(negedge clk);
    idle();
    checkStat("R2", 13'h0FF8);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 12'hFFF;
    @(negedge clk);
    idle();
    checkStat("R9", 13'h0000);

    // R1: reset in mid operation clears flags and enable
    evtPulse = 9'h020;
    @(negedge clk);
    idle();
    checkStat("R2", 13'h0100);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkStat("R1", 13'h0000);
    checkIrq("R1", 1'b0);
    lvlIn = 4'h4;
    repeat (2) @(negedge clk);
    checkIrq("R1", 1'b0);
    lvlIn = '0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule